// File: doc/BRIEF.md
# Chained Vector Issue Sequencer

This block sequences short vector instructions onto three functional units: a load unit, a multiply unit and an add unit. It accepts at most one instruction per cycle. Each instruction names a destination vector register and up to two source vector registers. A vector of 32 elements is split into element groups of 8, one element per lane. An instruction therefore occupies its unit for four group-cycles.

The units are chained. A consumer does not wait for its producer to finish the whole vector. It starts on group 0 as soon as the producer has written group 0, and it trails the producer by one cycle per group. A load, a dependent multiply and a dependent add issued on consecutive cycles run overlapped. For two cycles all three units process a group together, which is 24 element operations in one cycle.

Element data is abstracted away. The block tracks only how many groups of each register have been written. From that count it drives per-unit busy, fire, group index and completion outputs. A load-hold input stands in for memory delay.

Top module: `vseq_chain_seq`

## Requirements
- R1: After a synchronous active-low reset, the following hold:
  - every unit is idle, with group index 0 and no fire or done;
  - `in_ready` is high;
  - every register counts as fully written.
- R2: An accepted instruction starts its unit in the following cycle, at group 0.
  - The opcode selects the unit: 2'b00 load, 2'b01 multiply, 2'b10 add.
  - The unit then processes groups 0, 1, 2, 3, one per cycle while nothing holds it.
  - `unit_done` pulses in the cycle it processes group 3, and the unit is idle afterwards.
- R3: Opcode 2'b11 is always accepted and has no effect on any unit or register.
- R4: An instruction whose unit is busy keeps `in_ready` low. It is accepted in the cycle that unit processes its final group, and the new instruction starts the next cycle with no gap.
- R5: A unit processes group g of an instruction only after every non-self source has had group g written in an earlier cycle. While it waits, it stays busy, keeps its group index and does not fire.
- R6: A load, a multiply reading the load's result and an add reading the multiply's result are accepted on three consecutive cycles. All three units then fire together in exactly two cycles.
- R7: An instruction whose destination register still has a producer that has not written all four groups keeps `in_ready` low until that producer is done.
- R8: An instruction whose destination is a source of a busy multiply or add keeps `in_ready` low until that reader processes its final group.
- R9: While `in_ld_hold` is high, the load unit does not fire and keeps its group index.
- R10: A source equal to the instruction's own destination never delays that instruction, because the destination had no producer pending at issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_op | input | 2 | 00 load, 01 multiply, 10 add, 11 reserved |
| in_dst | input | 3 | Destination vector register |
| in_src1 | input | 3 | First source register (ignored by loads) |
| in_src2 | input | 3 | Second source register (ignored by loads) |
| in_ld_hold | input | 1 | Load unit cannot deliver a group this cycle |
| in_ready | output | 1 | Offered instruction is accepted at the clock edge when valid |
| unit_busy | output | 3 | Per unit (bit 0 load, 1 multiply, 2 add): an instruction is in progress |
| unit_fire | output | 3 | Per unit: a group is processed this cycle |
| unit_done | output | 3 | Per unit: the final group is processed this cycle |
| unit_grp | output | 6 | Per unit: 2-bit group index, unit 0 in the low bits |

## Verification
A wrong written-group count on a register shows up at `unit_fire` as a consumer that fires one cycle too early or that stalls with no cause. Both are visible in the first group-cycle after the fault. A wrong group index or busy flag in a unit shows up as a misplaced `unit_done` pulse or as a missing or extra fire inside the four-cycle window. A wrong hazard decision shows up as an accept cycle that differs from the expected count, with the whole run of the following instruction shifted.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
// Package: shared unit indices and opcode encoding for the chained
// vector issue sequencer. Assumes exactly three functional units.
package vseq_pkg;
    localparam int NUNITS = 3;
    localparam int U_LD   = 0;
    localparam int U_MUL  = 1;
    localparam int U_ADD  = 2;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_MUL  = 2'd1,
        OP_ADD  = 2'd2,
        OP_RSVD = 2'd3
    } vop_e;
endpackage

// File: rtl/vseq_unit.sv
`timescale 1ns/1ps
// Module: vseq_unit
// One functional unit's group sequencer. On start it latches the
// destination and sources, then walks group indices 0..GROUPS-1, one per
// cycle when not held and when every non-self source has that group
// written. Assumes start is only raised when idle or on the final group.
module vseq_unit
    import vseq_pkg::*;
#(
    parameter int GROUPS  = 4,
    parameter int NVREG   = 8,
    parameter bit HAS_SRC = 1'b1,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int CW = $clog2(GROUPS + 1),
    localparam int RW = (NVREG > 1) ? $clog2(NVREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [RW-1:0] dst_i,
    input  logic [RW-1:0] src1_i,
    input  logic [RW-1:0] src2_i,
    input  logic          hold_i,
    input  logic [CW-1:0] cnt1_i,
    input  logic [CW-1:0] cnt2_i,
    output logic          busy_o,
    output logic          fire_o,
    output logic          last_o,
    output logic          reads_o,
    output logic [GW-1:0] grp_o,
    output logic [RW-1:0] dst_o,
    output logic [RW-1:0] src1_o,
    output logic [RW-1:0] src2_o
);
    localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

    logic          busy_q;
    logic [GW-1:0] grp_q;
    logic [RW-1:0] dst_q;
    logic [RW-1:0] s1_q;
    logic [RW-1:0] s2_q;
    logic          self1_q;
    logic          self2_q;
    logic          operands_ok;

    // Operand readiness: the variant with sources compares written-group counts.
    generate
        if (HAS_SRC) begin : g_src
            assign operands_ok = (self1_q || (cnt1_i > CW'(grp_q))) &&
                                 (self2_q || (cnt2_i > CW'(grp_q)));
        end else begin : g_nosrc
            logic unused_srcs;
            assign unused_srcs = &{1'b0, cnt1_i, cnt2_i, self1_q, self2_q};
            assign operands_ok = 1'b1;
        end
    endgenerate

    assign fire_o  = busy_q && !hold_i && operands_ok;
    assign last_o  = fire_o && (grp_q == LAST_GRP);
    assign busy_o  = busy_q;
    assign reads_o = busy_q && HAS_SRC;
    assign grp_o   = grp_q;
    assign dst_o   = dst_q;
    assign src1_o  = s1_q;
    assign src2_o  = s2_q;

    // Instruction state: latch on start, step groups on fire, retire on last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            grp_q   <= '0;
            dst_q   <= '0;
            s1_q    <= '0;
            s2_q    <= '0;
            self1_q <= 1'b0;
            self2_q <= 1'b0;
        end else if (start_i) begin
            busy_q  <= 1'b1;
            grp_q   <= '0;
            dst_q   <= dst_i;
            s1_q    <= src1_i;
            s2_q    <= src2_i;
            self1_q <= (src1_i == dst_i);
            self2_q <= (src2_i == dst_i);
        end else if (last_o) begin
            busy_q  <= 1'b0;
            grp_q   <= '0;
        end else if (fire_o) begin
            grp_q   <= grp_q + 1'b1;
        end
    end
endmodule

// File: rtl/vseq_reg_track.sv
`timescale 1ns/1ps
// Module: vseq_reg_track
// Keeps, per vector register, how many element groups the current
// producer has written (GROUPS means complete). Issue to a register
// resets its count; a firing unit aimed at it records group+1.
// Assumes at most one unit targets a register at a time (issue enforces it).
module vseq_reg_track
    import vseq_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int NVREG  = 8,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int CW = $clog2(GROUPS + 1),
    localparam int RW = (NVREG > 1) ? $clog2(NVREG) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          issue_i,
    input  logic [RW-1:0]                 issue_dst_i,
    input  logic [NUNITS-1:0]             fire_i,
    input  logic [NUNITS-1:0][GW-1:0]     grp_i,
    input  logic [NUNITS-1:0][RW-1:0]     dst_i,
    output logic [NVREG-1:0][CW-1:0]      cnt_o
);
    generate
        for (genvar r = 0; r < NVREG; r++) begin : g_reg
            logic [CW-1:0] cnt_q;
            logic          wr_hit;
            logic [CW-1:0] wr_val;

            // Find the unit (if any) writing this register in this cycle.
            always_comb begin
                wr_hit = 1'b0;
                wr_val = cnt_q;
                for (int u = 0; u < NUNITS; u++) begin
                    if (fire_i[u] && (dst_i[u] == RW'(r))) begin
                        wr_hit = 1'b1;
                        wr_val = CW'(grp_i[u]) + 1'b1;
                    end
                end
            end

            // Written-group count: reset to complete, cleared on issue.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= CW'(GROUPS);
                end else if (issue_i && (issue_dst_i == RW'(r))) begin
                    cnt_q <= '0;
                end else if (wr_hit) begin
                    cnt_q <= wr_val;
                end
            end

            assign cnt_o[r] = cnt_q;
        end
    endgenerate
endmodule

// File: rtl/vseq_issue_ctl.sv
`timescale 1ns/1ps
// Module: vseq_issue_ctl
// In-order issue decision for one offered instruction. It stalls on a
// busy target unit (except in its final group), on a destination with an
// unfinished producer, and on a destination still read by a busy unit.
// Source registers under production do not stall: chaining handles them.
module vseq_issue_ctl
    import vseq_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int NVREG  = 8,
    localparam int CW = $clog2(GROUPS + 1),
    localparam int RW = (NVREG > 1) ? $clog2(NVREG) : 1
) (
    input  logic                      in_valid_i,
    input  logic [1:0]                op_i,
    input  logic [RW-1:0]             dst_i,
    input  logic [NUNITS-1:0]         busy_i,
    input  logic [NUNITS-1:0]         last_i,
    input  logic [NUNITS-1:0]         reads_i,
    input  logic [NUNITS-1:0][RW-1:0] rsrc1_i,
    input  logic [NUNITS-1:0][RW-1:0] rsrc2_i,
    input  logic [NVREG-1:0][CW-1:0]  cnt_i,
    output logic                      ready_o,
    output logic [NUNITS-1:0]         start_o
);
    logic rsvd;
    logic unit_free;
    logic waw;
    logic war;

    // Hazard evaluation and per-unit start decode.
    always_comb begin
        rsvd      = (op_i == OP_RSVD);
        unit_free = 1'b0;
        war       = 1'b0;
        for (int u = 0; u < NUNITS; u++) begin
            if (int'(op_i) == u) begin
                unit_free = !busy_i[u] || last_i[u];
            end
            if (reads_i[u] && !last_i[u] &&
                ((rsrc1_i[u] == dst_i) || (rsrc2_i[u] == dst_i))) begin
                war = 1'b1;
            end
        end
        waw     = (cnt_i[dst_i] != CW'(GROUPS));
        ready_o = rsvd || (unit_free && !waw && !war);
        start_o = '0;
        for (int u = 0; u < NUNITS; u++) begin
            if (in_valid_i && ready_o && !rsvd && (int'(op_i) == u)) begin
                start_o[u] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vseq_chain_seq.sv
`timescale 1ns/1ps
// Module: vseq_chain_seq (top)
// Chained vector issue sequencer for load, multiply and add units. Each
// instruction spans VLEN/LANES element groups, one per cycle per unit.
// Consumers chain on per-register written-group counts. Assumes VLEN is
// a multiple of LANES and that the unit count is fixed at three.
module vseq_chain_seq
    import vseq_pkg::*;
#(
    parameter int VLEN  = 32,
    parameter int LANES = 8,
    parameter int NVREG = 8,
    localparam int GROUPS = VLEN / LANES,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int CW = $clog2(GROUPS + 1),
    localparam int RW = (NVREG > 1) ? $clog2(NVREG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                in_op,
    input  logic [RW-1:0]             in_dst,
    input  logic [RW-1:0]             in_src1,
    input  logic [RW-1:0]             in_src2,
    input  logic                      in_ld_hold,
    output logic                      in_ready,
    output logic [NUNITS-1:0]         unit_busy,
    output logic [NUNITS-1:0]         unit_fire,
    output logic [NUNITS-1:0]         unit_done,
    output logic [NUNITS-1:0][GW-1:0] unit_grp
);
    logic [NUNITS-1:0]         u_start;
    logic [NUNITS-1:0]         u_reads;
    logic [NUNITS-1:0][RW-1:0] u_dst;
    logic [NUNITS-1:0][RW-1:0] u_src1;
    logic [NUNITS-1:0][RW-1:0] u_src2;
    logic [NVREG-1:0][CW-1:0]  reg_cnt;

    vseq_issue_ctl #(.GROUPS(GROUPS), .NVREG(NVREG)) u_issue (
        .in_valid_i (in_valid),
        .op_i       (in_op),
        .dst_i      (in_dst),
        .busy_i     (unit_busy),
        .last_i     (unit_done),
        .reads_i    (u_reads),
        .rsrc1_i    (u_src1),
        .rsrc2_i    (u_src2),
        .cnt_i      (reg_cnt),
        .ready_o    (in_ready),
        .start_o    (u_start)
    );

    vseq_reg_track #(.GROUPS(GROUPS), .NVREG(NVREG)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (|u_start),
        .issue_dst_i (in_dst),
        .fire_i      (unit_fire),
        .grp_i       (unit_grp),
        .dst_i       (u_dst),
        .cnt_o       (reg_cnt)
    );

    generate
        for (genvar u = 0; u < NUNITS; u++) begin : g_unit
            vseq_unit #(
                .GROUPS  (GROUPS),
                .NVREG   (NVREG),
                .HAS_SRC (u != U_LD)
            ) u_fu (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (u_start[u]),
                .dst_i   (in_dst),
                .src1_i  (in_src1),
                .src2_i  (in_src2),
                .hold_i  ((u == U_LD) ? in_ld_hold : 1'b0),
                .cnt1_i  (reg_cnt[u_src1[u]]),
                .cnt2_i  (reg_cnt[u_src2[u]]),
                .busy_o  (unit_busy[u]),
                .fire_o  (unit_fire[u]),
                .last_o  (unit_done[u]),
                .reads_o (u_reads[u]),
                .grp_o   (unit_grp[u]),
                .dst_o   (u_dst[u]),
                .src1_o  (u_src1[u]),
                .src2_o  (u_src2[u])
            );
        end
    endgenerate
endmodule

// File: rtl/vseq_chain_sva.sv
`timescale 1ns/1ps
// Module: vseq_chain_sva
// Checker bound to vseq_chain_seq: group stepping, stall holding,
// completion placement, load hold, issue start and the WAW guard.
module vseq_chain_sva
    import vseq_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int NVREG  = 8,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int CW = $clog2(GROUPS + 1),
    localparam int RW = (NVREG > 1) ? $clog2(NVREG) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [1:0]                in_op,
    input logic [RW-1:0]             in_dst,
    input logic                      in_ld_hold,
    input logic [NUNITS-1:0]         unit_busy,
    input logic [NUNITS-1:0]         unit_fire,
    input logic [NUNITS-1:0]         unit_done,
    input logic [NUNITS-1:0][GW-1:0] unit_grp,
    input logic [NVREG-1:0][CW-1:0]  reg_cnt
);
    generate
        for (genvar u = 0; u < NUNITS; u++) begin : g_chk
            AST_IDLE_AT_GRP0: assert property (@(posedge clk) disable iff (!rst_n)
                !unit_busy[u] |-> (unit_grp[u] == '0) && !unit_fire[u]); // R1
            AST_GRP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
                (unit_fire[u] && !unit_done[u]) |=>
                    unit_busy[u] && (unit_grp[u] == GW'($past(unit_grp[u]) + 1'b1))); // R2
            AST_DONE_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
                unit_done[u] |-> unit_fire[u] && (unit_grp[u] == GW'(GROUPS - 1))); // R2
            AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (unit_busy[u] && !unit_fire[u]) |=> unit_busy[u] && $stable(unit_grp[u])); // R5
            AST_START_GRP0: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready && (in_op == 2'(u))) |=>
                    unit_busy[u] && (unit_grp[u] == '0)); // R4
        end
    endgenerate

    AST_RSVD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 2'd3)) |-> in_ready); // R3
    AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_ld_hold |-> !unit_fire[U_LD]); // R9
    AST_WAW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_op != 2'd3)) |-> (reg_cnt[in_dst] == CW'(GROUPS))); // R7
endmodule

bind vseq_chain_seq vseq_chain_sva #(.GROUPS(GROUPS), .NVREG(NVREG)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op      (in_op),
    .in_dst     (in_dst),
    .in_ld_hold (in_ld_hold),
    .unit_busy  (unit_busy),
    .unit_fire  (unit_fire),
    .unit_done  (unit_done),
    .unit_grp   (unit_grp),
    .reg_cnt    (reg_cnt)
);

// File: tb/vseq_chain_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes expected (cycle, unit, group)
// items, the monitor pops them each cycle and compares the unit outputs.
module vseq_chain_seq_test;
    typedef struct {
        int    cyc;
        int    unit;
        int    grp;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [1:0]       in_op;
    logic [2:0]       in_dst, in_src1, in_src2;
    logic             in_ld_hold;
    logic             in_ready;
    logic [2:0]       unit_busy, unit_fire, unit_done;
    logic [2:0][1:0]  unit_grp;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   full_cnt = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;
    exp_t q[$];

    vseq_chain_seq uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_ld_hold(in_ld_hold), .in_ready(in_ready), .unit_busy(unit_busy),
        .unit_fire(unit_fire), .unit_done(unit_done), .unit_grp(unit_grp)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic expect_one(input int u, input int c, input int g, input string tag);
        exp_t e;
        e.cyc = c; e.unit = u; e.grp = g; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic expect_run(input int u, input int first, input string tag);
        for (int g = 0; g < 4; g++) expect_one(u, first + g, g, tag);
    endtask

    // Driver: offer one instruction from posedge+1 until accepted.
    task automatic issue(input logic [1:0] op, input logic [2:0] d,
                         input logic [2:0] s1, input logic [2:0] s2, output int acc);
        in_valid = 1'b1; in_op = op; in_dst = d; in_src1 = s1; in_src2 = s2;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        acc = cyc;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while ((unit_busy != 3'b000 || q.size() != 0) && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare fire, group and done of every unit against the queue.
    always @(negedge clk) begin
        bit    ef [3];
        int    eg [3];
        string et [3];
        if (mon_on) begin
            for (int u = 0; u < 3; u++) begin
                ef[u] = 1'b0; eg[u] = 0; et[u] = "R2";
            end
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].cyc == cyc) begin
                    ef[q[i].unit] = 1'b1;
                    eg[q[i].unit] = q[i].grp;
                    et[q[i].unit] = q[i].tag;
                    q.delete(i);
                end else if (q[i].cyc < cyc) begin
                    check(1'b0, q[i].tag, "stale expectation", q[i].cyc, cyc);
                    q.delete(i);
                end
            end
            for (int u = 0; u < 3; u++) begin
                check(unit_fire[u] == ef[u], et[u], $sformatf("unit %0d fire", u),
                      int'(unit_fire[u]), int'(ef[u]));
                if (ef[u]) begin
                    check(int'(unit_grp[u]) == eg[u], et[u], $sformatf("unit %0d group", u),
                          int'(unit_grp[u]), eg[u]);
                    check(unit_done[u] == (eg[u] == 3), et[u], $sformatf("unit %0d done", u),
                          int'(unit_done[u]), int'(eg[u] == 3));
                end else begin
                    check(!unit_done[u], et[u], $sformatf("unit %0d done idle", u),
                          int'(unit_done[u]), 0);
                end
            end
            if (unit_fire == 3'b111) full_cnt++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            report();
        end
    end

    initial begin
        int a0, a1, a2;
        rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; in_dst = 3'd0;
        in_src1 = 3'd0; in_src2 = 3'd0; in_ld_hold = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(unit_busy == 3'b000, "R1", "busy after reset", int'(unit_busy), 0);
        check(unit_grp == 6'd0, "R1", "groups after reset", int'(unit_grp), 0);
        check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
        @(posedge clk); #1;

        // R2: single load walks four groups then retires
        issue(2'b00, 3'd1, 3'd0, 3'd0, a0);
        expect_run(0, a0 + 1, "R2");
        wait_idle();
        check(unit_busy == 3'b000, "R2", "idle after run", int'(unit_busy), 0);

        // R6: load -> mul -> add chained on consecutive cycles
        full_cnt = 0;
        issue(2'b00, 3'd1, 3'd0, 3'd0, a0);
        expect_run(0, a0 + 1, "R6");
        issue(2'b01, 3'd2, 3'd1, 3'd3, a1);
        check(a1 == a0 + 1, "R6", "mul accept cycle", a1, a0 + 1);
        expect_run(1, a1 + 1, "R6");
        issue(2'b10, 3'd4, 3'd2, 3'd1, a2);
        check(a2 == a0 + 2, "R6", "add accept cycle", a2, a0 + 2);
        expect_run(2, a2 + 1, "R6");
        wait_idle();
        check(full_cnt == 2, "R6", "cycles with all units firing", full_cnt, 2);

        // R4: same unit back to back, handoff in final group
        issue(2'b00, 3'd1, 3'd0, 3'd0, a0);
        expect_run(0, a0 + 1, "R4");
        issue(2'b00, 3'd2, 3'd0, 3'd0, a1);
        check(a1 == a0 + 4, "R4", "second load accept cycle", a1, a0 + 4);
        expect_run(0, a1 + 1, "R4");
        wait_idle();

        // R3: reserved opcode accepted with no effect
        issue(2'b11, 3'd5, 3'd0, 3'd0, a0);
        @(negedge clk);
        check(unit_busy == 3'b000, "R3", "busy after reserved op", int'(unit_busy), 0);
        @(posedge clk); #1;
        issue(2'b10, 3'd5, 3'd6, 3'd7, a1);
        check(a1 == a0 + 2, "R3", "add to same dst not stalled", a1, a0 + 2);
        expect_run(2, a1 + 1, "R3");
        wait_idle();

        // R7: destination with an unfinished producer stalls issue
        issue(2'b00, 3'd5, 3'd0, 3'd0, a0);
        expect_run(0, a0 + 1, "R7");
        issue(2'b10, 3'd5, 3'd6, 3'd7, a1);
        check(a1 == a0 + 5, "R7", "WAW accept cycle", a1, a0 + 5);
        expect_run(2, a1 + 1, "R7");
        wait_idle();

        // R8: destination still read by a busy unit stalls issue
        issue(2'b01, 3'd2, 3'd3, 3'd4, a0);
        expect_run(1, a0 + 1, "R8");
        issue(2'b00, 3'd3, 3'd0, 3'd0, a1);
        check(a1 == a0 + 4, "R8", "WAR accept cycle", a1, a0 + 4);
        expect_run(0, a1 + 1, "R8");
        wait_idle();

        // R9 / R5: load held one cycle, chained multiply waits on group 1
        issue(2'b00, 3'd1, 3'd0, 3'd0, a0);
        expect_one(0, a0 + 1, 0, "R9");
        expect_one(0, a0 + 3, 1, "R9");
        expect_one(0, a0 + 4, 2, "R9");
        expect_one(0, a0 + 5, 3, "R9");
        issue(2'b01, 3'd2, 3'd1, 3'd3, a1);
        check(a1 == a0 + 1, "R5", "chained mul accept cycle", a1, a0 + 1);
        expect_one(1, a0 + 2, 0, "R5");
        expect_one(1, a0 + 4, 1, "R5");
        expect_one(1, a0 + 5, 2, "R5");
        expect_one(1, a0 + 6, 3, "R5");
        in_ld_hold = 1'b1;
        @(posedge clk); #1;
        in_ld_hold = 1'b0;
        @(negedge clk);
        check(unit_busy[0] && unit_grp[0] == 2'd1, "R9", "held load group",
              int'(unit_grp[0]), 1);
        check(unit_busy[1] && unit_grp[1] == 2'd1, "R5", "waiting mul group",
              int'(unit_grp[1]), 1);
        @(posedge clk); #1;
        wait_idle();

        // R10: source equal to own destination does not stall
        issue(2'b10, 3'd4, 3'd4, 3'd0, a0);
        expect_run(2, a0 + 1, "R10");
        wait_idle();

        check(q.size() == 0, "R2", "expectations left", q.size(), 0);
        report();
    end
endmodule